// File: doc/BRIEF.md
# Pulse Update Spreading Queue

This block sits between a computation engine and two pulse output lines. Early in each processing frame the engine writes a short burst of updates, each carrying one sign bit per output. The block holds them in an eight-entry queue and releases one per programmed interval, so the pulse edges are spread over the frame instead of arriving together.

A frame-start strobe empties the queue and restarts the interval timer. Updates still queued at that point are discarded. If the interval register is zero, the queue is bypassed and each written update reaches the outputs at once.

A width limiter cuts off a pulse that stays active for too many consecutive updates. A single invert bit selects whether the lines are active low (the default) or active high.

Top module: `pulse_spread_fifo`

## Requirements
- R1: After reset neither channel is active, so with `invert`=0 both `pulse_out` bits read 1. No update happens until one is written.
- R2: With `interval` nonzero, up to 8 updates written in a frame are released in write order, one per timer expiry. In `upd_sign`, bit 0 drives channel 0 (`pulse_out[0]`) and bit 1 drives channel 1 (`pulse_out[1]`). A sign of 1 makes that channel active.
- R3: Let N be a nonzero `interval` value, and let the frame-start strobe be sampled at clock edge E. The k-th queued update shows at the outputs just after edge E+4·N·k and not before.
- R4: A frame-start strobe discards every queued update that has not yet been released. Those entries never reach the outputs.
- R5: A write made while 8 updates are already queued is dropped. The update at the 9th expiry slot therefore leaves the outputs unchanged.
- R6: A timer expiry while the queue is empty leaves both outputs unchanged.
- R7: With `interval`=0, a write updates the outputs on the clock edge that samples it.
- R8: With `max_width`=M below 255, a channel stays active for at most 2·M+1 consecutive updates. The next active update forces the channel inactive. Its run count then restarts, so the active update after that begins a new pulse. An inactive update also restarts the count.
- R9: With `max_width`=255, no width limit applies, and the outputs follow the released sign bits.
- R10: `invert`=0 drives an active channel low. `invert`=1 drives it high. The bit acts on both lines combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start-of-frame strobe: clears the queue and restarts the timer |
| upd_valid | input | 1 | Update write strobe |
| upd_sign | input | 2 | Sign bits of the update, one per channel |
| interval | input | 8 | Release spacing in units of 4 clocks; 0 selects bypass |
| max_width | input | 8 | Width limit M, giving 2·M+1 updates; 255 disables the limit |
| invert | input | 1 | 1 selects active-high outputs |
| pulse_out | output | 2 | Pulse lines |

## Verification
A queued update is due just after edge E+4·N·k, counted from the edge that samples the frame strobe. A bypass write is due one edge after it is driven, and a change of `invert` is due in the same cycle. Inputs change on the falling edge, and the bench counts falling edges from the frame strobe. It samples `pulse_out` once on the falling edge just before each due edge, where the old value must still hold, and again just after it, where the new value must appear. A reference model at the update level tracks each channel's level and run count, and that model sets every expected value.

// File: rtl/pulse_spread_fifo.sv
module pulse_spread_fifo #(
  parameter int DEPTH = 8,
  parameter int IW    = 8,
  parameter int MW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          upd_valid,
  input  logic [1:0]    upd_sign,
  input  logic [IW-1:0] interval,
  input  logic [MW-1:0] max_width,
  input  logic          invert,
  output logic [1:0]    pulse_out
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = IW + 2;
  localparam int RW = MW + 1;

  logic [1:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmr;
  logic          trun;
  logic [1:0]    lvl;

  wire          bypass   = (interval == '0);
  wire          full     = (cnt == CW'(DEPTH));
  wire          push     = upd_valid && !bypass && (frame_start || !full);
  wire          tick     = trun && (tmr == '0) && !frame_start;
  wire          pop      = tick && (cnt != '0);
  wire          upd      = pop || (bypass && upd_valid);
  wire [1:0]    nsign    = bypass ? upd_sign : mem[rp];
  wire          limit_on = (max_width != '1);
  wire [RW-1:0] nmax     = {max_width, 1'b1};
  wire [TW-1:0] reload   = {interval, 2'b00} - TW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trun <= 1'b0;
      tmr  <= '0;
    end else if (frame_start || tick) begin
      trun <= !bypass;
      tmr  <= reload;
    end else if (trun && tmr != '0) begin
      tmr <= tmr - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (frame_start) begin
      rp  <= '0;
      wp  <= push ? PW'(1) : '0;
      cnt <= push ? CW'(1) : '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[frame_start ? '0 : wp] <= upd_sign;
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic          act_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= 1'b0;
        run_q <= '0;
      end else if (upd) begin
        if (!nsign[c] || !limit_on) begin
          act_q <= nsign[c];
          run_q <= '0;
        end else if (run_q == nmax) begin
          act_q <= 1'b0;
          run_q <= '0;
        end else begin
          act_q <= 1'b1;
          run_q <= run_q + RW'(1);
        end
      end
    end

    assign lvl[c] = act_q;

    // R8
    width_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd && limit_on && nsign[c] && run_q == nmax |=> !act_q);
  end

  assign pulse_out = invert ? lvl : ~lvl;

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R4
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> cnt <= CW'(1));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(lvl));

  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass && upd_valid && !limit_on |=> lvl == $past(upd_sign));
endmodule

// File: tb/pulse_spread_fifo_tb_top.sv
module pulse_spread_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0, upd_valid = 1'b0, invert = 1'b0;
  logic [1:0] upd_sign = '0;
  logic [7:0] interval = '0, max_width = 8'd255;
  logic [1:0] pulse_out;

  always #4 clk = ~clk;

  pulse_spread_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .upd_valid(upd_valid),
    .upd_sign(upd_sign), .interval(interval), .max_width(max_width),
    .invert(invert), .pulse_out(pulse_out)
  );

  // {interval, max_width, invert, count, signs (entry i at bits 2i+1:2i)}
  localparam int NV = 7;
  localparam logic [40:0] VEC [NV] = '{
    {8'd3, 8'd255, 1'b0, 4'd4,  20'h00039},
    {8'd5, 8'd255, 1'b1, 4'd3,  20'h00007},
    {8'd3, 8'd0,   1'b0, 4'd4,  20'h0003F},
    {8'd3, 8'd1,   1'b0, 4'd6,  20'h00555},
    {8'd3, 8'd255, 1'b0, 4'd8,  20'h06666},
    {8'd3, 8'd255, 1'b1, 4'd10, 20'h53333},
    {8'd4, 8'd2,   1'b0, 4'd7,  20'h02AAA}
  };

  int checks = 0, fails = 0;
  logic [1:0] mlvl = '0;
  int mrun [2] = '{0, 0};

  function automatic logic [1:0] pins(logic [1:0] l, logic inv);
    return inv ? l : ~l;
  endfunction

  task automatic chk(string tag, logic [1:0] exp);
    checks++;
    if (pulse_out !== exp) begin
      fails++;
      $display("FAIL %s: pulse_out=%b expected %b", tag, pulse_out, exp);
    end
  endtask

  task automatic mdl_upd(logic [1:0] s, int mw);
    for (int c = 0; c < 2; c++) begin
      if (!s[c] || mw == 255) begin
        mlvl[c] = s[c]; mrun[c] = 0;
      end else if (mrun[c] == 2 * mw + 1) begin
        mlvl[c] = 1'b0; mrun[c] = 0;
      end else begin
        mlvl[c] = 1'b1; mrun[c]++;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int m;
    logic [1:0] tgt;
    repeat (3) @(negedge clk);
    chk("R1 in reset", 2'b11);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after reset", 2'b11);

    for (int v = 0; v < NV; v++) begin
      logic [7:0]  iv, mw;
      logic        inv;
      int          n, stored;
      logic [19:0] sg;
      iv = VEC[v][40:33]; mw = VEC[v][32:25]; inv = VEC[v][24];
      n = int'(VEC[v][23:20]); sg = VEC[v][19:0];
      stored = (n > 8) ? 8 : n;
      interval = iv; max_width = mw; invert = inv; frame_start = 1'b1;
      @(negedge clk); frame_start = 1'b0; m = 1;
      for (int i = 0; i < n; i++) begin
        upd_valid = 1'b1; upd_sign = sg[2*i +: 2];
        @(negedge clk); m++;
      end
      upd_valid = 1'b0;
      for (int k = 1; k <= stored + 1; k++) begin
        while (m < 4 * int'(iv) * k) begin @(negedge clk); m++; end
        chk("R3 before due edge", pins(mlvl, inv));
        @(negedge clk); m++;
        if (k <= stored) begin
          mdl_upd(sg[2*(k-1) +: 2], int'(mw));
          chk(mw == 8'd255 ? "R2 R9 release" : "R2 R8 release", pins(mlvl, inv));
        end else begin
          chk(n > 8 ? "R5 dropped write" : "R6 empty expiry", pins(mlvl, inv));
        end
      end
    end

    // R10: invert acts in the same cycle
    invert = ~invert; #1;
    chk("R10 invert toggle", pins(mlvl, invert));
    invert = 1'b0; #1;
    chk("R10 active low", pins(mlvl, 1'b0));

    // R7: bypass, then bypass with width limit (R8)
    @(negedge clk);
    interval = 8'd0; max_width = 8'd255;
    foreach (VEC[i]) begin
      if (i < 3) begin
        upd_sign = (i == 1) ? 2'b01 : 2'b10; upd_valid = 1'b1; #1;
        chk("R7 no change before edge", pins(mlvl, 1'b0));
        @(negedge clk);
        mdl_upd(upd_sign, 255);
        chk("R7 bypass update", pins(mlvl, 1'b0));
      end
    end
    max_width = 8'd0;
    for (int i = 0; i < 3; i++) begin
      upd_sign = 2'b11; upd_valid = 1'b1;
      @(negedge clk);
      mdl_upd(2'b11, 0);
      chk("R7 R8 bypass width cut", pins(mlvl, 1'b0));
    end
    upd_valid = 1'b0;

    // R4: frame restart discards queued entries
    interval = 8'd10; max_width = 8'd255;
    tgt = ~mlvl;
    frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0; m = 1;
    for (int i = 0; i < 3; i++) begin
      upd_valid = 1'b1; upd_sign = tgt;
      @(negedge clk); m++;
    end
    upd_valid = 1'b0;
    while (m < 20) begin @(negedge clk); m++; end
    frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0; m = 1;
    while (m < 41) begin @(negedge clk); m++; end
    chk("R4 discarded after first expiry", pins(mlvl, 1'b0));
    while (m < 81) begin @(negedge clk); m++; end
    chk("R4 discarded after second expiry", pins(mlvl, 1'b0));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule